// File: doc/BRIEF.md
# Compact Branch Target and State-Exchange Unit

This unit sits beside the decoder of a processor that runs two instruction sets: a 32-bit one and a denser 16-bit one. Each cycle it may accept one 16-bit instruction with its address. If the instruction is a branch, the unit works out where the program goes next. There are four kinds of branch.

- A conditional branch carries a short signed offset.
- An unconditional jump carries a wider signed offset.
- A long call is split across two instructions. The unit holds the upper part of the offset between them.
- A register-indirect exchange branch jumps to an address taken from a register. Bit 0 of that register also chooses which instruction set runs next.

The unit does not evaluate condition codes: the surrounding logic supplies a pass/fail input. The register file is outside the unit too, so the value of the exchange register comes in as a port. While the core runs 32-bit code, the 16-bit instruction input is not used. The 32-bit side can still ask for an exchange through its own request input, and that is how execution first enters 16-bit code after reset.

All results are registered. They appear in the cycle after the instruction is accepted, and they are:

- a taken pulse with the target address;
- a link-register write with the return value, for a long call only;
- the current state bit. Software sees this bit at position 5 of its status word, but the unit itself only drives the bit.

Top module: `cbx_unit`

## Requirements
- R1: After reset, br_taken and lr_we are 0 and narrow_state is 0, which selects the 32-bit instruction set.
- R2: In narrow state, an accepted instruction whose bits [15:12] are 1101, and whose bits [11:8] are neither 1110 nor 1111, is a conditional branch. If cond_pass is 1, the next cycle shows br_taken=1 with br_target = pc_in + 4 + (sign-extended bits [7:0]) × 2. If cond_pass is 0, the next cycle shows br_taken=0.
- R3: An instruction with bits [15:12]=1101 and bits [11:8] equal to 1110 or 1111 is not a branch: br_taken stays 0 whatever cond_pass is.
- R4: Bits [15:11]=11100 form an unconditional jump. The next cycle shows br_taken=1 with br_target = pc_in + 4 + (sign-extended bits [10:0]) × 2, whatever cond_pass is.
- R5: Bits [15:11]=11110 form the first half of a long call. It produces no br_taken and no lr_we. It stores pc_in + 4 + (sign-extended bits [10:0]) × 4096 as the pending upper target.
- R6: Bits [15:11]=11111, accepted straight after a first half, form the second half of a long call. The next cycle shows br_taken=1 and br_target = stored value + (bits [10:0], zero-extended) × 2. In the same cycle lr_we=1 with lr_data = (pc_in + 2) with bit 0 set.
- R7: A second half is ignored (no br_taken, no lr_we) if the previously accepted event was not a first half. Cycles in which nothing is accepted do not break a pair.
- R8: Bits [15:7]=010001110 with bits [2:0]=000 form an exchange branch. The next cycle shows br_taken=1 and narrow_state = reg_val[0]. br_target is reg_val with bit 0 cleared when reg_val[0]=1, and with bits [1:0] cleared when reg_val[0]=0.
- R9: While narrow_state=0, instr_valid is ignored. A pulse on wide_xchg then performs the R8 exchange using reg_val. While narrow_state=1, wide_xchg is ignored.
- R10: br_taken and lr_we last one cycle for each accepted event. narrow_state changes only in a cycle where br_taken=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A 16-bit instruction is presented this cycle |
| instr | input | 16 | The 16-bit instruction |
| pc_in | input | 32 | Address of the presented instruction |
| cond_pass | input | 1 | The external condition test passed |
| reg_val | input | 32 | Value of the register named by an exchange branch |
| wide_xchg | input | 1 | Exchange request from the 32-bit side |
| br_taken | output | 1 | A branch is taken; br_target is valid |
| br_target | output | 32 | Branch target address |
| lr_we | output | 1 | Link register write strobe |
| lr_data | output | 32 | Value to write into the link register |
| narrow_state | output | 1 | 1 when running 16-bit instructions |

## Verification
The assertions check, on every cycle, the rules that need no arithmetic:

- a link write always comes with a taken branch and an odd return value;
- the state bit moves only on a taken branch;
- an unmatched second half or a failed condition gives no branch;
- in 32-bit state nothing is taken without an exchange request;
- a branch into 32-bit state lands word-aligned.

Only the bench scenarios can show that the target sums are right at the offset extremes. They also show that a pair broken by another instruction is dropped, and that the two reserved condition values are not treated as branches.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_COND    = 3'd1,
        K_JUMP    = 3'd2,
        K_LONG_HI = 3'd3,
        K_LONG_LO = 3'd4,
        K_XCHG    = 3'd5
    } br_kind_e;

endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
    import cbx_pkg::*;
#(
    parameter int COND_W = 8,
    parameter int JUMP_W = 11,
    parameter int LONG_W = 11
) (
    input  logic [15:0]       instr,
    output br_kind_e          kind,
    output logic [COND_W-1:0] off_cond,
    output logic [JUMP_W-1:0] off_jump,
    output logic [LONG_W-1:0] off_long
);

    logic cond_reserved;

    // Condition values 1110 and 1111 are reserved and never decode as a branch (R3).
    assign cond_reserved = (instr[11:9] == 3'b111);

    always_comb begin
        kind = K_NONE;
        if (instr[15:12] == 4'b1101) begin
            if (!cond_reserved) kind = K_COND;
        end else if (instr[15:11] == 5'b11100) begin
            kind = K_JUMP;
        end else if (instr[15:11] == 5'b11110) begin
            kind = K_LONG_HI;
        end else if (instr[15:11] == 5'b11111) begin
            kind = K_LONG_LO;
        end else if (instr[15:7] == 9'b010001110 && instr[2:0] == 3'b000) begin
            kind = K_XCHG;
        end
    end

    assign off_cond = instr[COND_W-1:0];
    assign off_jump = instr[JUMP_W-1:0];
    assign off_long = instr[LONG_W-1:0];

endmodule

// File: rtl/cbx_target.sv
module cbx_target
    import cbx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int COND_W = 8,
    parameter int JUMP_W = 11,
    parameter int LONG_W = 11
) (
    input  br_kind_e          kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] hold,
    input  logic [COND_W-1:0] off_cond,
    input  logic [JUMP_W-1:0] off_jump,
    input  logic [LONG_W-1:0] off_long,
    output logic [ADDR_W-1:0] rel_target,
    output logic [ADDR_W-1:0] hold_next,
    output logic [ADDR_W-1:0] ret_addr
);

    // The upper half of a long call is shifted past the lower half and its halfword bit.
    localparam int HI_SHIFT = LONG_W + 1;

    logic [ADDR_W-1:0] pc_ahead;
    logic [ADDR_W-1:0] ext_cond;
    logic [ADDR_W-1:0] ext_jump;
    logic [ADDR_W-1:0] ext_hi;
    logic [ADDR_W-1:0] ext_lo;

    // The PC reads as the instruction address plus 4.
    assign pc_ahead = pc + ADDR_W'(4);

    assign ext_cond = {{(ADDR_W-COND_W-1){off_cond[COND_W-1]}}, off_cond, 1'b0};
    assign ext_jump = {{(ADDR_W-JUMP_W-1){off_jump[JUMP_W-1]}}, off_jump, 1'b0};
    assign ext_hi   = {{(ADDR_W-LONG_W-HI_SHIFT){off_long[LONG_W-1]}}, off_long, {HI_SHIFT{1'b0}}};
    assign ext_lo   = {{(ADDR_W-LONG_W-1){1'b0}}, off_long, 1'b0};

    always_comb begin
        unique case (kind)
            K_COND:    rel_target = pc_ahead + ext_cond;
            K_JUMP:    rel_target = pc_ahead + ext_jump;
            K_LONG_LO: rel_target = hold + ext_lo;
            default:   rel_target = pc_ahead;
        endcase
    end

    assign hold_next = pc_ahead + ext_hi;
    // The return point is the instruction after the second half, with bit 0 marking 16-bit state.
    assign ret_addr  = (pc + ADDR_W'(2)) | ADDR_W'(1);

endmodule

// File: rtl/cbx_xchg.sv
module cbx_xchg #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] reg_val,
    output logic              new_state,
    output logic [ADDR_W-1:0] xchg_target
);

    assign new_state = reg_val[0];

    // 16-bit state is halfword aligned; 32-bit state is word aligned.
    always_comb begin
        if (reg_val[0]) xchg_target = {reg_val[ADDR_W-1:1], 1'b0};
        else            xchg_target = {reg_val[ADDR_W-1:2], 2'b00};
    end

endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
    import cbx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int COND_W = 8,
    parameter int JUMP_W = 11,
    parameter int LONG_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              cond_pass,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic              wide_xchg,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic              lr_we,
    output logic [ADDR_W-1:0] lr_data,
    output logic              narrow_state
);

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              lr_we;
        logic [ADDR_W-1:0] lr_data;
        logic              nstate;
        logic [ADDR_W-1:0] hold;
        logic              hold_v;
    } unit_st_t;

    unit_st_t st_d, st_q;

    br_kind_e          kind;
    logic [COND_W-1:0] off_cond;
    logic [JUMP_W-1:0] off_jump;
    logic [LONG_W-1:0] off_long;
    logic [ADDR_W-1:0] rel_target;
    logic [ADDR_W-1:0] hold_next;
    logic [ADDR_W-1:0] ret_addr;
    logic              x_state;
    logic [ADDR_W-1:0] x_target;
    logic              use_narrow;
    logic              use_wide;

    cbx_decode #(
        .COND_W (COND_W),
        .JUMP_W (JUMP_W),
        .LONG_W (LONG_W)
    ) u_dec (
        .instr    (instr),
        .kind     (kind),
        .off_cond (off_cond),
        .off_jump (off_jump),
        .off_long (off_long)
    );

    cbx_target #(
        .ADDR_W (ADDR_W),
        .COND_W (COND_W),
        .JUMP_W (JUMP_W),
        .LONG_W (LONG_W)
    ) u_tgt (
        .kind       (kind),
        .pc         (pc_in),
        .hold       (st_q.hold),
        .off_cond   (off_cond),
        .off_jump   (off_jump),
        .off_long   (off_long),
        .rel_target (rel_target),
        .hold_next  (hold_next),
        .ret_addr   (ret_addr)
    );

    cbx_xchg #(
        .ADDR_W (ADDR_W)
    ) u_xchg (
        .reg_val     (reg_val),
        .new_state   (x_state),
        .xchg_target (x_target)
    );

    // R9: the 16-bit input is used only in narrow state, the wide request only outside it.
    assign use_narrow = st_q.nstate & instr_valid;
    assign use_wide   = ~st_q.nstate & wide_xchg;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.lr_we = 1'b0;
        if (use_narrow) begin
            // Any accepted event except a first half breaks a pending pair (R7).
            st_d.hold_v = 1'b0;
            unique case (kind)
                K_COND: begin
                    if (cond_pass) begin
                        st_d.taken  = 1'b1;
                        st_d.target = rel_target;
                    end
                end
                K_JUMP: begin
                    st_d.taken  = 1'b1;
                    st_d.target = rel_target;
                end
                K_LONG_HI: begin
                    st_d.hold   = hold_next;
                    st_d.hold_v = 1'b1;
                end
                K_LONG_LO: begin
                    if (st_q.hold_v) begin
                        st_d.taken   = 1'b1;
                        st_d.target  = rel_target;
                        st_d.lr_we   = 1'b1;
                        st_d.lr_data = ret_addr;
                    end
                end
                K_XCHG: begin
                    st_d.taken  = 1'b1;
                    st_d.target = x_target;
                    st_d.nstate = x_state;
                end
                default: ;
            endcase
        end else if (use_wide) begin
            st_d.hold_v = 1'b0;
            st_d.taken  = 1'b1;
            st_d.target = x_target;
            st_d.nstate = x_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign br_taken     = st_q.taken;
    assign br_target    = st_q.target;
    assign lr_we        = st_q.lr_we;
    assign lr_data      = st_q.lr_data;
    assign narrow_state = st_q.nstate;

    // R6: a link write only comes with the branch it belongs to.
    p_link_with_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> br_taken);

    // R6: the return value marks 16-bit state.
    p_link_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> lr_data[0]);

    // R7: a second half with no pending first half produces nothing.
    p_orphan_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (use_narrow && kind == K_LONG_LO && !st_q.hold_v) |=> (!br_taken && !lr_we));

    // R2: a failed condition gives no branch.
    p_cond_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_narrow && kind == K_COND && !cond_pass) |=> !br_taken);

    // R9: in 32-bit state nothing is taken without an exchange request.
    p_wide_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!narrow_state && !wide_xchg) |=> !br_taken);

    // R10: the state bit moves only on a taken branch.
    p_state_moves_on_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(narrow_state) |-> br_taken);

    // R8: a branch that lands in 32-bit state is word aligned.
    p_wide_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !narrow_state) |-> (br_target[1:0] == 2'b00));

endmodule

// File: tb/sim_cbx_unit.sv
`timescale 1ns/1ps
module sim_cbx_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr;
    logic [31:0] pc_in;
    logic        cond_pass;
    logic [31:0] reg_val;
    logic        wide_xchg;
    logic        br_taken;
    logic [31:0] br_target;
    logic        lr_we;
    logic [31:0] lr_data;
    logic        narrow_state;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state, kept by the bench
    logic        m_state = 1'b0;
    logic [31:0] m_hold  = '0;
    logic        m_hv    = 1'b0;

    always #2 clk = ~clk;

    cbx_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr        (instr),
        .pc_in        (pc_in),
        .cond_pass    (cond_pass),
        .reg_val      (reg_val),
        .wide_xchg    (wide_xchg),
        .br_taken     (br_taken),
        .br_target    (br_target),
        .lr_we        (lr_we),
        .lr_data      (lr_data),
        .narrow_state (narrow_state)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // 0 none, 1 cond, 2 jump, 3 long hi, 4 long lo, 5 exchange
    function automatic int kind_of(input logic [15:0] i);
        if (i[15:12] == 4'b1101)                       return (i[11:9] == 3'b111) ? 0 : 1;
        if (i[15:11] == 5'b11100)                      return 2;
        if (i[15:11] == 5'b11110)                      return 3;
        if (i[15:11] == 5'b11111)                      return 4;
        if (i[15:7] == 9'b010001110 && i[2:0] == 3'd0) return 5;
        return 0;
    endfunction

    function automatic logic [31:0] xchg_tgt(input logic [31:0] r);
        return r[0] ? (r & 32'hFFFF_FFFE) : (r & 32'hFFFF_FFFC);
    endfunction

    task automatic send(input logic v, input logic [15:0] ins, input logic [31:0] p,
                        input logic cp, input logic [31:0] r, input logic w, input string tag);
        logic        e_tk  = 1'b0;
        logic        e_lw  = 1'b0;
        logic [31:0] e_tg  = '0;
        logic [31:0] e_ld  = '0;
        int          k     = kind_of(ins);
        if (m_state && v) begin
            m_hv = 1'b0;
            case (k)
                1: if (cp) begin e_tk = 1'b1; e_tg = p + 32'd4 + {{23{ins[7]}}, ins[7:0], 1'b0}; end
                2: begin e_tk = 1'b1; e_tg = p + 32'd4 + {{20{ins[10]}}, ins[10:0], 1'b0}; end
                3: begin m_hold = p + 32'd4 + {{9{ins[10]}}, ins[10:0], 12'd0}; m_hv = 1'b1; end
                4: if (m_hv_prev(k)) begin
                       e_tk = 1'b1; e_lw = 1'b1;
                       e_tg = m_hold + {20'd0, ins[10:0], 1'b0};
                       e_ld = (p + 32'd2) | 32'd1;
                   end
                5: begin e_tk = 1'b1; e_tg = xchg_tgt(r); m_state = r[0]; end
                default: ;
            endcase
        end else if (!m_state && w) begin
            m_hv = 1'b0;
            e_tk = 1'b1; e_tg = xchg_tgt(r); m_state = r[0];
        end
        prev_hv = m_hv;
        @(negedge clk);
        instr_valid = v; instr = ins; pc_in = p; cond_pass = cp; reg_val = r; wide_xchg = w;
        @(posedge clk);
        #1;
        chk(tag, "br_taken", {31'd0, br_taken}, {31'd0, e_tk});
        chk(tag, "lr_we", {31'd0, lr_we}, {31'd0, e_lw});
        chk(tag, "narrow_state", {31'd0, narrow_state}, {31'd0, m_state});
        if (e_tk) chk(tag, "br_target", br_target, e_tg);
        if (e_lw) chk(tag, "lr_data", lr_data, e_ld);
        instr_valid = 1'b0; wide_xchg = 1'b0;
    endtask

    // The pair flag as it stood before the current event cleared it
    logic prev_hv = 1'b0;
    function automatic logic m_hv_prev(input int k);
        return (k == 4) && prev_hv;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0; pc_in = '0;
        cond_pass = 1'b0; reg_val = '0; wide_xchg = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "br_taken", {31'd0, br_taken}, 32'd0);
        chk("R1", "lr_we", {31'd0, lr_we}, 32'd0);
        chk("R1", "narrow_state", {31'd0, narrow_state}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R9: 16-bit input ignored in 32-bit state, then enter narrow state by wide request
        send(1, 16'hE010, 32'h100, 1, 32'h0, 0, "R9");
        send(0, 16'h0, 32'h0, 0, 32'h0000_1001, 1, "R9");
        // R9: wide request ignored in narrow state
        send(0, 16'h0, 32'h0, 0, 32'h0000_8000, 1, "R9");
        // R2: condition fails, then passes at minimum offset
        send(1, 16'hD080, 32'h1000, 0, 32'h0, 0, "R2");
        send(1, 16'hD180, 32'h1000, 1, 32'h0, 0, "R2");
        send(1, 16'hD07F, 32'h1000, 1, 32'h0, 0, "R2");
        // R10: idle cycle after a branch
        send(0, 16'h0, 32'h0, 0, 32'h0, 0, "R10");
        // R3: reserved condition values
        send(1, 16'hDF12, 32'h1000, 1, 32'h0, 0, "R3");
        send(1, 16'hDE12, 32'h1000, 1, 32'h0, 0, "R3");
        // R4: jump extremes, condition input irrelevant
        send(1, 16'hE3FF, 32'h2000, 0, 32'h0, 0, "R4");
        send(1, 16'hE400, 32'h2000, 1, 32'h0, 0, "R4");
        // R5 R6: long call with negative upper half, idle cycle inside the pair
        send(1, 16'hF7FF, 32'h0040_0000, 0, 32'h0, 0, "R5");
        send(0, 16'h0, 32'h0, 0, 32'h0, 0, "R7");
        send(1, 16'hFFFF, 32'h0040_0002, 0, 32'h0, 0, "R6");
        // R6: positive upper half at maximum
        send(1, 16'hF3FF, 32'h0000_0100, 0, 32'h0, 0, "R5");
        send(1, 16'hF801, 32'h0000_0102, 0, 32'h0, 0, "R6");
        // R7: orphan second half, and a pair broken by another instruction
        send(1, 16'hF822, 32'h300, 0, 32'h0, 0, "R7");
        send(1, 16'hF010, 32'h300, 0, 32'h0, 0, "R7");
        send(1, 16'hD105, 32'h302, 0, 32'h0, 0, "R7");
        send(1, 16'hF822, 32'h304, 0, 32'h0, 0, "R7");
        // R8: exchange staying narrow, then leaving to 32-bit state
        send(1, 16'h4708, 32'h400, 0, 32'h0000_2003, 0, "R8");
        send(1, 16'h4710, 32'h402, 0, 32'h0000_3006, 0, "R8");
        send(1, 16'hD105, 32'h500, 1, 32'h0, 0, "R9");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int          c  = int'($urandom % 8);
            logic [15:0] ri = 16'($urandom);
            logic [31:0] rp = $urandom & 32'hFFFF_FFFE;
            logic [31:0] rr = $urandom;
            logic        rw = ($urandom % 4) == 0;
            logic        rc = 1'($urandom);
            case (c)
                0: ri = {4'b1101, ri[11:0]};
                1: ri = {5'b11100, ri[10:0]};
                2: ri = {5'b11110, ri[10:0]};
                3: ri = {5'b11111, ri[10:0]};
                4: ri = {9'b010001110, ri[6:3], 3'b000};
                5: ri = {5'b11110, ri[10:0]};
                default: ;
            endcase
            send(c != 7, ri, rp, rc, rr, rw, "R10");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule